// File: doc/BRIEF.md
# JTAG Host Scan Sequencer

This block is a JTAG master for a single target device. It makes TCK by dividing the system clock and drives TMS and TDI. It samples TDO and gathers the returned bits into a result word. A short command port accepts one of three operations: bring the target's TAP controller to Run-Test/Idle from any state, load an instruction, or scan a data register of a chosen length. The block walks the TAP through the required states with fixed TMS patterns. It shifts the payload out least significant bit first and returns to Run-Test/Idle at the end of every command.

A command is offered with `cmd_valid` and is taken only while `cmd_ready` is high. `busy` stays high until the last TCK cycle of the command has ended. At that point a one-cycle `done` pulse marks `result` as updated. TCK rests high between commands. TMS and TDI change only as TCK falls, and TDO is sampled as TCK rises.

Top module: `jtag_host_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `tck` is 1. After reset `tms`, `tdi`, `done`, `busy` and `result` are 0 and `cmd_ready` is 1.
- R2: Every TCK cycle of a command spends exactly `HALF_DIV` system clocks low, then `HALF_DIV` system clocks high.
- R3: Opcode 0 (reset-to-idle) gives 9 TCK rising edges. TMS is 1 on the first eight and 0 on the ninth, so a target in any TAP state ends in Run-Test/Idle.
- R4: Opcode 1 (instruction load) gives 11 TCK rising edges with TMS 1,1,0,0,0,0,0,0,1,1,0. The five shift edges carry `cmd_data[4:0]` on TDI, least significant bit first, and the target's instruction register then holds that value.
- R5: Opcode 2 (data scan) of effective length L gives L+5 TCK rising edges with TMS 1,0,0, then L−1 zeros, then 1,1,0. The L shift edges carry `cmd_data[L-1:0]` on TDI, least significant bit first.
- R6: `tms` and `tdi` change only in the system clock in which `tck` falls. Outside the shift edges, `tdi` is 0.
- R7: TDO is sampled on each TCK rising edge of a shift. The first bit lands in bit 0 of `result`, and bits above the shift length are 0. An instruction load returns its 5 captured bits in `result[4:0]`. A reset-to-idle returns 0. `result` changes only in the cycle `done` is high.
- R8: `cmd_ready` is the inverse of `busy`. `busy` rises the cycle after a command is taken. `done` is a single-cycle pulse raised as `busy` falls, with `tck` high and `tms` low. A `cmd_valid` seen while `busy` is high is ignored.
- R9: The effective data scan length is `cmd_len` clipped to the range 1 to `DATA_W`: 0 scans 1 bit and any value above `DATA_W` scans `DATA_W` bits.
- R10: Opcode 3 is never taken: it causes no TCK edge and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 reset-to-idle, 1 instruction load, 2 data scan, 3 not taken |
| cmd_len | input | LEN_W (6) | Data scan length in bits |
| cmd_data | input | DATA_W (32) | Bits to shift out, LSB first |
| cmd_ready | output | 1 | Command can be taken |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W (32) | Captured TDO bits, right-aligned |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
The assertions assume that `tdo` is driven to a known level whenever a shift edge samples it. They also assume `cmd_op` and `cmd_len` are known whenever `cmd_valid` is high. The bench meets both conditions with a model target TAP that drives TDO from registered state on TCK falling edges and rests at 0 outside shifts. The bench drives every command field to a defined value before it raises `cmd_valid`. Random lengths come from the full 6-bit field, and the directed cases at 0 and above `DATA_W` cover the clipping rule.

// File: rtl/jhs_pkg.sv
`timescale 1ns/1ps
package jhs_pkg;

  typedef enum logic [1:0] {
    JOP_RESET = 2'd0,
    JOP_IR    = 2'd1,
    JOP_DR    = 2'd2,
    JOP_NONE  = 2'd3
  } jop_e;

  localparam int RESET_HI = 8;  // TMS-high clocks before the final low one

  // clocks spent walking from Run-Test/Idle into the shift state
  function automatic int walk_bits(jop_e op);
    case (op)
      JOP_IR:  return 4;
      JOP_DR:  return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int shift_bits(jop_e op, int len, int ir_w);
    case (op)
      JOP_IR:  return ir_w;
      JOP_DR:  return len;
      default: return 0;
    endcase
  endfunction

  function automatic int total_bits(jop_e op, int len, int ir_w);
    if (op == JOP_RESET) return RESET_HI + 1;
    return walk_bits(op) + shift_bits(op, len, ir_w) + 2;
  endfunction

  function automatic logic tms_at(jop_e op, int idx, int len, int ir_w);
    int w;
    int s;
    if (op == JOP_RESET) return idx < RESET_HI;
    w = walk_bits(op);
    s = shift_bits(op, len, ir_w);
    if (idx < w) return (op == JOP_IR) ? (idx < 2) : (idx == 0);
    if (idx < w + s) return idx == w + s - 1;  // last shift bit exits
    return idx == w + s;                       // Exit1 -> Update, then Idle
  endfunction

  function automatic logic in_shift(jop_e op, int idx, int len, int ir_w);
    int w;
    w = walk_bits(op);
    return (op != JOP_RESET) && (idx >= w) && (idx < w + shift_bits(op, len, ir_w));
  endfunction

  function automatic int clamp_len(int raw, int max_w);
    if (raw < 1) return 1;
    if (raw > max_w) return max_w;
    return raw;
  endfunction

endpackage

// File: rtl/jhs_tck_gen.sv
`timescale 1ns/1ps
module jhs_tck_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic more,
  output logic tck,
  output logic fall_evt,
  output logic rise_evt,
  output logic end_evt
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          phase_done;

  assign phase_done = (cnt == LAST);
  assign fall_evt   = active && tck && phase_done && more;
  assign rise_evt   = active && !tck && phase_done;
  assign end_evt    = active && tck && phase_done && !more;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt <= LAST;
      tck <= 1'b1;
    end else if (phase_done) begin
      cnt <= '0;
      if (fall_evt)      tck <= 1'b0;
      else if (rise_evt) tck <= 1'b1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  generate
    if (HALF > 1) begin : g_phase_chk
      p_min_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tck != $past(tck)) |=> (tck == $past(tck)));
    end
  endgenerate

endmodule

// File: rtl/jhs_seq.sv
`timescale 1ns/1ps
module jhs_seq
  import jhs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IR_W   = 5,
  parameter int LEN_W  = 6,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              tck,
  input  logic              fall_evt,
  input  logic              end_evt,
  output logic              accept,
  output logic              busy,
  output logic              cmd_ready,
  output logic              done,
  output logic              more,
  output logic              cur_shift,
  output logic [LEN_W-1:0]  nbits,
  output logic              tms,
  output logic              tdi
);
  jop_e              op_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] dsr;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  tot_q;
  logic [LEN_W-1:0]  len_eff;
  logic [IDX_W-1:0]  tot_eff;
  logic              tms_now;
  logic              sh_now;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy && (cmd_op != JOP_NONE);
  assign more      = (idx_q != tot_q);
  assign len_eff   = LEN_W'(clamp_len(int'(cmd_len), DATA_W));
  assign tot_eff   = IDX_W'(total_bits(jop_e'(cmd_op), int'(len_eff), IR_W));
  assign nbits     = LEN_W'(shift_bits(op_q, int'(len_q), IR_W));

  always_comb begin
    tms_now = tms_at(op_q, int'(idx_q), int'(len_q), IR_W);
    sh_now  = in_shift(op_q, int'(idx_q), int'(len_q), IR_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      op_q      <= JOP_RESET;
      len_q     <= LEN_W'(1);
      dsr       <= '0;
      idx_q     <= '0;
      tot_q     <= '0;
      cur_shift <= 1'b0;
      tms       <= 1'b0;
      tdi       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        op_q  <= jop_e'(cmd_op);
        len_q <= len_eff;
        dsr   <= cmd_data;
        idx_q <= '0;
        tot_q <= tot_eff;
      end else if (fall_evt) begin
        tms       <= tms_now;
        cur_shift <= sh_now;
        tdi       <= sh_now ? dsr[0] : 1'b0;
        if (sh_now) dsr <= dsr >> 1;
        idx_q     <= idx_q + IDX_W'(1);
      end else if (end_evt) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // pins move only with the falling edge of TCK
  p_pins_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tms != $past(tms)) || (tdi != $past(tdi))) |-> (!tck && $past(tck)));

  // completion: TAP parked in Idle with TCK high
  p_done_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && tck && !tms));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op != 2'd3)) |=> busy);

endmodule

// File: rtl/jhs_capture.sv
`timescale 1ns/1ps
module jhs_capture #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tck,
  input  logic              rise_evt,
  input  logic              end_evt,
  input  logic              cur_shift,
  input  logic              tdo,
  input  logic [LEN_W-1:0]  nbits,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] cap;

  // bits enter at the top; move the n newest down to bit 0
  function automatic logic [DATA_W-1:0] align_right(logic [DATA_W-1:0] v, logic [LEN_W-1:0] n);
    if (n == '0) return '0;
    return v >> (DATA_W - int'(n));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap    <= '0;
      result <= '0;
    end else begin
      if (clear)                      cap <= '0;
      else if (rise_evt && cur_shift) cap <= {tdo, cap[DATA_W-1:1]};
      if (end_evt)                    result <= align_right(cap, nbits);
    end
  end

  p_cap_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap != $past(cap)) |-> ($rose(tck) || $past(clear)));

endmodule

// File: rtl/jtag_host_seq.sv
`timescale 1ns/1ps
module jtag_host_seq #(
  parameter int DATA_W   = 32,
  parameter int IR_W     = 5,
  parameter int HALF_DIV = 2,
  localparam int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  localparam int IDX_W = $clog2(DATA_W + IR_W + 8);

  logic             accept;
  logic             more;
  logic             fall_evt;
  logic             rise_evt;
  logic             end_evt;
  logic             cur_shift;
  logic [LEN_W-1:0] nbits;

  jhs_tck_gen #(.HALF(HALF_DIV)) u_tck (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (busy),
    .more     (more),
    .tck      (tck),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt),
    .end_evt  (end_evt)
  );

  jhs_seq #(.DATA_W(DATA_W), .IR_W(IR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_len   (cmd_len),
    .cmd_data  (cmd_data),
    .tck       (tck),
    .fall_evt  (fall_evt),
    .end_evt   (end_evt),
    .accept    (accept),
    .busy      (busy),
    .cmd_ready (cmd_ready),
    .done      (done),
    .more      (more),
    .cur_shift (cur_shift),
    .nbits     (nbits),
    .tms       (tms),
    .tdi       (tdi)
  );

  jhs_capture #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .tck       (tck),
    .rise_evt  (rise_evt),
    .end_evt   (end_evt),
    .cur_shift (cur_shift),
    .tdo       (tdo),
    .nbits     (nbits),
    .result    (result)
  );

  p_tck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tck);

  p_result_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result)) |-> done);

endmodule

// File: tb/jtag_host_seq_tb.sv
`timescale 1ns/1ps
module jtag_host_seq_tb_top;
  localparam int HALF = 2;
  localparam logic [31:0] ID_VAL = 32'h3B2C_91A7;

  typedef enum logic [3:0] {
    T_TLR, T_RTI, T_SDS, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
    T_SIS, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
  } tap_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [5:0]  cmd_len = 6'd0;
  logic [31:0] cmd_data = 32'd0;
  logic        cmd_ready, busy, done, tck, tms, tdi;
  logic [31:0] result;
  logic        tdo = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  jtag_host_seq #(.DATA_W(32), .IR_W(5), .HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .result(result), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo)
  );

  always #5 clk = ~clk;

  // ---------------- model target TAP ----------------
  tap_t        tap_st = T_TLR;
  logic [4:0]  tap_ir = 5'h1E;
  logic [4:0]  ir_sr = 5'd0;
  logic [31:0] dr_sr = 32'd0;
  logic [31:0] tap_scr = 32'd0;
  int          edges = 0;
  logic [63:0] tms_log = '0;

  function automatic tap_t tap_next(tap_t s, logic m);
    case (s)
      T_TLR:  return m ? T_TLR  : T_RTI;
      T_RTI:  return m ? T_SDS  : T_RTI;
      T_SDS:  return m ? T_SIS  : T_CDR;
      T_CDR:  return m ? T_E1DR : T_SHDR;
      T_SHDR: return m ? T_E1DR : T_SHDR;
      T_E1DR: return m ? T_UDR  : T_PDR;
      T_PDR:  return m ? T_E2DR : T_PDR;
      T_E2DR: return m ? T_UDR  : T_SHDR;
      T_UDR:  return m ? T_SDS  : T_RTI;
      T_SIS:  return m ? T_TLR  : T_CIR;
      T_CIR:  return m ? T_E1IR : T_SHIR;
      T_SHIR: return m ? T_E1IR : T_SHIR;
      T_E1IR: return m ? T_UIR  : T_PIR;
      T_PIR:  return m ? T_E2IR : T_PIR;
      T_E2IR: return m ? T_UIR  : T_SHIR;
      default: return m ? T_SDS : T_RTI;
    endcase
  endfunction

  function automatic bit wide_dr(logic [4:0] ir);
    return (ir == 5'h1E) || (ir == 5'h02);
  endfunction

  always @(posedge tck) if (rst_n) begin
    case (tap_st)
      T_TLR:  tap_ir = 5'h1E;
      T_CDR:  dr_sr = (tap_ir == 5'h1E) ? ID_VAL : (tap_ir == 5'h02) ? tap_scr : 32'd0;
      T_SHDR: if (wide_dr(tap_ir)) dr_sr = {tdi, dr_sr[31:1]}; else dr_sr[0] = tdi;
      T_UDR:  if (tap_ir == 5'h02) tap_scr = dr_sr;
      T_CIR:  ir_sr = 5'b00001;
      T_SHIR: ir_sr = {tdi, ir_sr[4:1]};
      T_UIR:  tap_ir = ir_sr;
      default: ;
    endcase
    if (edges < 64) tms_log[edges] = tms;
    edges++;
    tap_st = tap_next(tap_st, tms);
  end

  always @(negedge tck) if (rst_n)
    tdo = (tap_st == T_SHDR) ? dr_sr[0] : (tap_st == T_SHIR) ? ir_sr[0] : 1'b0;

  // ---------------- pin monitors (R2, R6) ----------------
  time t_fall = 0;
  int  bad_phase = 0;
  int  bad_pin = 0;
  logic p_tms = 1'b0, p_tdi = 1'b0, p_tck = 1'b1;

  always @(negedge tck) if (rst_n) t_fall = $time;
  always @(posedge tck) if (rst_n && ($time - t_fall) != HALF * 10) bad_phase++;

  always @(negedge clk) if (rst_n) begin
    if (((tms !== p_tms) || (tdi !== p_tdi)) && !(tck == 1'b0 && p_tck == 1'b1)) bad_pin++;
    if (!busy && tck !== 1'b1) bad_pin++;
    p_tms = tms; p_tdi = tdi; p_tck = tck;
  end

  // ---------------- reference functions ----------------
  function automatic int eff_len(int raw);
    return (raw == 0) ? 1 : (raw > 32) ? 32 : raw;
  endfunction

  function automatic int exp_edges(int op, int len);
    return (op == 0) ? 9 : (op == 1) ? 11 : len + 5;
  endfunction

  function automatic logic [63:0] exp_tms(int op, int len);
    logic [63:0] v = '0;
    if (op == 0) v[7:0] = 8'hFF;
    else if (op == 1) begin v[0] = 1; v[1] = 1; v[8] = 1; v[9] = 1; end
    else begin v[0] = 1; v[len + 2] = 1; v[len + 3] = 1; end
    return v;
  endfunction

  function automatic logic [63:0] lowmask(int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [5:0] len,
                         input logic [31:0] data, input bit poke);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_len = len; cmd_data = data;
    edges = 0; tms_log = '0;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R8 busy after accept", {62'd0, busy, cmd_ready}, 64'd2);
    if (poke) begin
      repeat (3) @(negedge clk);
      cmd_valid = 1; cmd_op = 2'd1; cmd_data = 32'h8;
      @(negedge clk);
      cmd_valid = 0;
    end
    while (!done) @(negedge clk);
    chk(!busy && cmd_ready && tck, "R8 parked at done", {61'd0, busy, cmd_ready, tck}, 64'd3);
  endtask

  task automatic check_seq(input int op, input int len, input string tag);
    chk(edges == exp_edges(op, len), {tag, " edge count"}, edges, exp_edges(op, len));
    chk((tms_log & lowmask(edges)) == exp_tms(op, len), {tag, " tms pattern"},
        tms_log & lowmask(edges), exp_tms(op, len));
    chk(tap_st == T_RTI, {tag, " ends in idle"}, tap_st, T_RTI);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] scr_ref;
    logic [31:0] d;
    int          l;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    chk(tck && !tms && !tdi && !done && !busy && cmd_ready && result == 0, "R1 reset state",
        {result, 26'd0, tck, tms, tdi, done, busy, cmd_ready}, 64'h21);

    // R3: reset-to-idle from random TAP states
    for (int i = 0; i < 5; i++) begin
      tap_st = tap_t'($urandom_range(15, 0));
      run_cmd(2'd0, 6'd0, 32'hFFFF_FFFF, 0);
      check_seq(0, 0, "R3");
      chk(result == 0, "R7 reset result", result, 0);
      chk(tap_ir == 5'h1E, "R3 via test-logic-reset", tap_ir, 5'h1E);
    end

    // R4: load ID instruction; captured IR pattern returned
    run_cmd(2'd1, 6'd0, 32'hFFFF_FFFE, 0);
    check_seq(1, 0, "R4");
    chk(tap_ir == 5'h1E, "R4 instruction", tap_ir, 5'h1E);
    chk(result == 32'h1, "R7 ir capture", result, 32'h1);

    // R5/R7: full and partial ID scans
    run_cmd(2'd2, 6'd32, 32'hA5A5_5A5A, 0);
    check_seq(2, 32, "R5 id32");
    chk(result == ID_VAL, "R7 id32", result, ID_VAL);
    run_cmd(2'd2, 6'd8, 32'h0, 0);
    check_seq(2, 8, "R5 id8");
    chk(result == (ID_VAL & 32'hFF), "R7 id8", result, ID_VAL & 32'hFF);

    // bypass: TDI echoed one bit late behind a captured 0
    run_cmd(2'd1, 6'd0, 32'h1F, 0);
    chk(tap_ir == 5'h1F, "R4 bypass instr", tap_ir, 5'h1F);
    for (int i = 0; i < 6; i++) begin
      d = $urandom(); l = $urandom_range(32, 1);
      run_cmd(2'd2, 6'(l), d, 0);
      check_seq(2, l, "R5 bypass");
      chk(result == 32'(({32'd0, d, 1'b0}) & lowmask(l)), "R5 bypass tdi order",
          result, ({32'd0, d, 1'b0}) & lowmask(l));
    end

    // scratch register: readback of old contents, write of new
    run_cmd(2'd1, 6'd0, 32'h02, 0);
    chk(tap_ir == 5'h02, "R4 scratch instr", tap_ir, 5'h02);
    scr_ref = 32'hC0DE_1234;
    tap_scr = scr_ref;
    for (int i = 0; i < 20; i++) begin
      d = $urandom(); l = $urandom_range(63, 0);
      run_cmd(2'd2, 6'(l), d, 0);
      l = eff_len(l);
      check_seq(2, l, "R9 scan");
      chk(result == 32'(scr_ref & lowmask(l)), "R7 scratch readback", result, scr_ref & lowmask(l));
      scr_ref = (l == 32) ? d : ((scr_ref >> l) | (d << (32 - l)));
      chk(tap_scr == scr_ref, "R5 scratch write", tap_scr, scr_ref);
    end

    // R9 directed clipping
    run_cmd(2'd2, 6'd0, 32'h1, 0);
    check_seq(2, 1, "R9 len0");
    scr_ref = (scr_ref >> 1) | 32'h8000_0000;
    run_cmd(2'd2, 6'd45, 32'h1357_9BDF, 0);
    check_seq(2, 32, "R9 len45");
    chk(result == scr_ref, "R9 len45 data", result, scr_ref);
    scr_ref = 32'h1357_9BDF;

    // R8: command offered while busy is dropped
    run_cmd(2'd2, 6'd12, 32'hABC, 1);
    check_seq(2, 12, "R8 busy ignore");
    repeat (20) @(negedge clk);
    chk(!busy && edges == 17 && tap_ir == 5'h02, "R8 no late start", {busy, 31'd0, 27'd0, tap_ir}, 64'd2);

    // R10: opcode 3 is not taken
    @(negedge clk);
    edges = 0; cmd_valid = 1; cmd_op = 2'd3;
    @(negedge clk); cmd_valid = 0;
    repeat (12) @(negedge clk);
    chk(!busy && tck && edges == 0, "R10 op3 ignored", {busy, tck, 30'd0, 32'(edges)}, 64'h4000_0000_0000_0000);

    chk(bad_phase == 0, "R2 low phase length", bad_phase, 0);
    chk(bad_pin == 0, "R6 pin change timing", bad_pin, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog actual=busy expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule